// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense Unit

This block is a single 32-pin bank of a memory-mapped GPIO interrupt unit. Each input line passes through a two-stage synchronizer. For every pin, the unit compares the current synchronized sample with the previous one to find edges, or tests the sample directly to find a level. The kind of event watched for on each pin comes from a 3-bit code. That code is built from the same bit position in three separate trigger-mode registers.

Each detected event sets a bit in a sticky event register. Software clears those bits by writing ones. A per-pin enable mask selects which event bits may drive the bank's single interrupt line, and that line is registered once.

The bank also holds an output latch that drives the pin outputs. Software reads that latch back through its own address. The value address returns the synchronized input sample instead, so a write followed at once by a read of the value address does not necessarily show the written data. Access is through a plain 32-bit register port: writes take effect on a clock edge and reads are combinational.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `pins_o` is 0. The default mode is therefore falling-edge sensing with all interrupts masked.
- R2: The value register (offset 0x00 on read) returns the input pins after two synchronizer stages. A change on `pins_i` becomes visible on the second rising clock edge after it.
- R3: With type code {t2,t1,t0} = 000, only a 1-to-0 change of the synchronized sample sets the pin's event bit. A 0-to-1 change does not.
- R4: With code 001 (t1=0, t0=1), only a 0-to-1 change sets the event bit.
- R5: With t1=0 and t2=1, both directions of change set the event bit, whatever t0 holds.
- R6: With t1=1, the event bit is set on every cycle the synchronized sample equals t0 (t0=1 senses high, t0=0 senses low). In this mode t2 has no effect.
- R7: Writing the event register (offset 0x14) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When an event and a clear of the same bit fall on the same clock edge, the bit stays set. In level mode this means a clear has no lasting effect while the level persists.
- R9: `irq_o` is the OR over all pins of (event bit AND enable bit), registered once. Event bits whose enable bit is 0 never raise `irq_o`.
- R10: A write to offset 0x00 loads the output latch. `pins_o` follows the latch, and offset 0x18 reads it back on the cycle after the write. Writes to 0x18 are ignored.
- R11: The register map is: value/latch 0x00, enable 0x04, t0 0x08, t1 0x0C, t2 0x10, events 0x14, latch readback 0x18. The enable and the three type registers read back what was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Asynchronous input lines |
| pins_o | output | 32 | Output latch contents |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered bank interrupt |

## Verification
The checks on the synchronizer assume that `pins_i` holds 0 while reset is asserted, because its stage-delay property only becomes active two edges after reset. The write-one-to-clear and set-wins checks assume that at most one write strobe is presented per edge, with address and data stable around that edge. The bench changes pins and register-port inputs only on the falling clock edge. It holds the pins at 0 during reset, and it changes a pin only after the previous event has had four cycles to settle, so each edge is seen as exactly one change of the synchronized sample.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_VALUE    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IRQ_BASE = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_EN       = OFS_IRQ_BASE + 8'h00;
  localparam logic [ADDR_W-1:0] OFS_T0       = OFS_IRQ_BASE + 8'h04;
  localparam logic [ADDR_W-1:0] OFS_T1       = OFS_IRQ_BASE + 8'h08;
  localparam logic [ADDR_W-1:0] OFS_T2       = OFS_IRQ_BASE + 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_EVT      = OFS_IRQ_BASE + 8'h10;
  localparam logic [ADDR_W-1:0] OFS_LATCH    = 8'h18;

  typedef enum logic [2:0] {
    SENSE_FALL,
    SENSE_RISE,
    SENSE_BOTH,
    SENSE_LOW,
    SENSE_HIGH
  } sense_e;

  // code = {t2, t1, t0}; level mode ignores t2, both-edge overrides t0
  function automatic sense_e decode_sense(logic [2:0] code);
    if (code[1])      return code[0] ? SENSE_HIGH : SENSE_LOW;
    else if (code[2]) return SENSE_BOTH;
    else              return code[0] ? SENSE_RISE : SENSE_FALL;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] smp_o
);
  logic [NPINS-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= pins_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign smp_o = st_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      logic [1:0] age_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      assert_sync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) |-> (smp_o == $past(pins_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] smp_i,
  input  logic [NPINS-1:0] t0_i,
  input  logic [NPINS-1:0] t1_i,
  input  logic [NPINS-1:0] t2_i,
  output logic [NPINS-1:0] evt_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;
  end

  for (genvar g = 0; g < int'(NPINS); g++) begin : g_pin
    logic   rise, fall, hit;
    sense_e mode;
    assign rise = smp_i[g] & ~prev_q[g];
    assign fall = ~smp_i[g] & prev_q[g];
    assign mode = decode_sense({t2_i[g], t1_i[g], t0_i[g]});
    always_comb begin
      case (mode)
        SENSE_RISE: hit = rise;
        SENSE_BOTH: hit = rise | fall;
        SENSE_HIGH: hit = smp_i[g];
        SENSE_LOW:  hit = ~smp_i[g];
        default:    hit = fall;
      endcase
    end
    assign evt_o[g] = hit;
  end

  // edge-mode events only when the sample actually moved
  assert_edge_needs_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_o & ~t1_i & ~(smp_i ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  smp_i,
  input  logic [NPINS-1:0]  evt_i,
  output logic [NPINS-1:0]  t0_o,
  output logic [NPINS-1:0]  t1_o,
  output logic [NPINS-1:0]  t2_o,
  output logic [NPINS-1:0]  latch_o,
  output logic              irq_o
);
  logic [NPINS-1:0] en_q, t0_q, t1_q, t2_q, evt_q, latch_q, clr_mask;
  logic             irq_q;

  assign clr_mask = (wr_en_i && addr_i == OFS_EVT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      t0_q    <= '0;
      t1_q    <= '0;
      t2_q    <= '0;
      latch_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_VALUE: latch_q <= wdata_i;
        OFS_EN:    en_q    <= wdata_i;
        OFS_T0:    t0_q    <= wdata_i;
        OFS_T1:    t1_q    <= wdata_i;
        OFS_T2:    t2_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(evt_q & en_q);
  end

  always_comb begin
    case (addr_i)
      OFS_VALUE: rdata_o = smp_i;
      OFS_EN:    rdata_o = en_q;
      OFS_T0:    rdata_o = t0_q;
      OFS_T1:    rdata_o = t1_q;
      OFS_T2:    rdata_o = t2_q;
      OFS_EVT:   rdata_o = evt_q;
      OFS_LATCH: rdata_o = latch_q;
      default:   rdata_o = '0;
    endcase
  end

  assign t0_o    = t0_q;
  assign t1_o    = t1_q;
  assign t2_o    = t2_q;
  assign latch_o = latch_q;
  assign irq_o   = irq_q;

  assert_evt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_q) & ~$past(clr_mask) & ~evt_q) == '0));
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_i) & ~evt_q) == '0));
  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & en_q) == '0) |=> !irq_o);
  assert_latch_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_VALUE) |=> (latch_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pins_i,
  output logic [NPINS-1:0]  pins_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] smp, evt, t0, t1, t2;

  gpio_irq_sync #(.NPINS(NPINS), .STAGES(STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (pins_i),
    .smp_o  (smp)
  );

  gpio_irq_detect #(.NPINS(NPINS)) i_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (smp),
    .t0_i   (t0),
    .t1_i   (t1),
    .t2_i   (t2),
    .evt_o  (evt)
  );

  gpio_irq_regs #(.NPINS(NPINS)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .smp_i   (smp),
    .evt_i   (evt),
    .t0_o    (t0),
    .t1_o    (t1),
    .t2_o    (t2),
    .latch_o (pins_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins_i = '0;
  logic [31:0] pins_o;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  localparam logic [7:0] A_VAL = 8'h00, A_EN = 8'h04, A_T0 = 8'h08, A_T1 = 8'h0C,
                         A_T2 = 8'h10, A_EVT = 8'h14, A_LAT = 8'h18;

  always #4 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins_i), .pins_o(pins_o),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    chk_rd("R1 value", A_VAL, 0);
    chk_rd("R1 en", A_EN, 0);
    chk_rd("R1 t0", A_T0, 0);
    chk_rd("R1 t1", A_T1, 0);
    chk_rd("R1 t2", A_T2, 0);
    chk_rd("R1 evt", A_EVT, 0);
    chk_rd("R1 latch", A_LAT, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 pins_o", pins_o, 0);
  endtask

  task automatic t_map();
    wr(A_T0, 32'hFFFF_FFFF);
    wr(A_T1, 32'h5A5A_5A5A);
    wr(A_T2, 32'h0F0F_0F0F);
    wr(A_EN, 32'h1234_5678);
    chk_rd("R11 t0", A_T0, 32'hFFFF_FFFF);
    chk_rd("R11 t1", A_T1, 32'h5A5A_5A5A);
    chk_rd("R11 t2", A_T2, 32'h0F0F_0F0F);
    chk_rd("R11 en", A_EN, 32'h1234_5678);
    chk_rd("R11 evt untouched", A_EVT, 0);
    wr(A_T1, 0); wr(A_T0, 0); wr(A_T2, 0); wr(A_EN, 0);
    chk_rd("R11 t1 restore", A_T1, 0);
  endtask

  task automatic t_sync_fall();
    pins_i = 32'h1234_5678;
    chk_rd("R2 before edge", A_VAL, 0);
    wait_n(1);
    chk_rd("R2 after one stage", A_VAL, 0);
    wait_n(1);
    chk_rd("R2 after two stages", A_VAL, 32'h1234_5678);
    wait_n(3);
    chk_rd("R3 rise ignored", A_EVT, 0);
    pins_i = 0;
    wait_n(4);
    chk_rd("R3 fall sets", A_EVT, 32'h1234_5678);
  endtask

  task automatic t_w1c();
    wr(A_EVT, 32'h0000_FFFF);
    chk_rd("R7 partial clear", A_EVT, 32'h1234_0000);
    wr(A_EVT, 0);
    chk_rd("R7 zero write keeps", A_EVT, 32'h1234_0000);
    wr(A_EVT, 32'hFFFF_FFFF);
    chk_rd("R7 full clear", A_EVT, 0);
  endtask

  task automatic t_rise();
    wr(A_T0, 32'hFFFF_FFFF);
    pins_i = 32'h0000_000F;
    wait_n(4);
    chk_rd("R4 rise sets", A_EVT, 32'h0000_000F);
    wr(A_EVT, 32'hFFFF_FFFF);
    pins_i = 0;
    wait_n(4);
    chk_rd("R4 fall ignored", A_EVT, 0);
    wr(A_T0, 0);
  endtask

  task automatic t_both();
    wr(A_T2, 32'hFFFF_FFFF);
    wr(A_T0, 32'h0000_00F0);
    pins_i = 32'h0000_00FF;
    wait_n(4);
    chk_rd("R5 both rise", A_EVT, 32'h0000_00FF);
    wr(A_EVT, 32'hFFFF_FFFF);
    pins_i = 0;
    wait_n(4);
    chk_rd("R5 both fall", A_EVT, 32'h0000_00FF);
    wr(A_EVT, 32'hFFFF_FFFF);
    chk_rd("R5 cleared", A_EVT, 0);
  endtask

  task automatic t_level();
    wr(A_T0, 32'hFFFF_FFFF);
    wr(A_T1, 32'hFFFF_FFFF);
    pins_i = 32'h0000_0003;
    wait_n(4);
    chk_rd("R6 high sets", A_EVT, 32'h0000_0003);
    wr(A_EVT, 32'hFFFF_FFFF);
    chk_rd("R8 level re-sets after clear", A_EVT, 32'h0000_0003);
    pins_i = 0;
    wait_n(4);
    wr(A_EVT, 32'hFFFF_FFFF);
    chk_rd("R6 t2 ignored in level", A_EVT, 0);
    wr(A_T0, 0);
    wait_n(1);
    chk_rd("R6 low sets", A_EVT, 32'hFFFF_FFFF);
    wr(A_T1, 0);
    wr(A_EVT, 32'hFFFF_FFFF);
    chk_rd("R6 back to edge", A_EVT, 0);
    wr(A_T2, 0);
  endtask

  task automatic t_setwins();
    wr(A_T0, 32'hFFFF_FFFF);
    pins_i = 32'h0000_0100;
    wait_n(2);
    wr(A_EVT, 32'h0000_0100);
    chk_rd("R8 set beats clear", A_EVT, 32'h0000_0100);
    wr(A_EVT, 32'h0000_0100);
    chk_rd("R8 later clear", A_EVT, 0);
    pins_i = 0;
    wait_n(4);
    wr(A_T0, 0);
  endtask

  task automatic t_irq();
    wr(A_T0, 32'hFFFF_FFFF);
    pins_i = 32'h0000_0005;
    wait_n(4);
    chk_rd("R9 events present", A_EVT, 32'h0000_0005);
    check("R9 masked", {31'b0, irq}, 0);
    wr(A_EN, 32'h0000_0002);
    wait_n(2);
    check("R9 other bit enabled", {31'b0, irq}, 0);
    wr(A_EN, 32'h0000_0004);
    check("R9 registered delay", {31'b0, irq}, 0);
    wait_n(1);
    check("R9 asserted", {31'b0, irq}, 1);
    wr(A_EVT, 32'h0000_0004);
    wait_n(1);
    check("R9 deasserted", {31'b0, irq}, 0);
    wr(A_EN, 0);
    wr(A_EVT, 32'hFFFF_FFFF);
    pins_i = 0;
    wait_n(4);
    wr(A_T0, 0);
  endtask

  task automatic t_latch();
    pins_i = 32'h0000_AAAA;
    wait_n(4);
    wr(A_VAL, 32'hDEAD_BEEF);
    chk_rd("R10 readback", A_LAT, 32'hDEAD_BEEF);
    check("R10 pins_o", pins_o, 32'hDEAD_BEEF);
    chk_rd("R10 value is sample", A_VAL, 32'h0000_AAAA);
    wr(A_LAT, 0);
    chk_rd("R10 readback write ignored", A_LAT, 32'hDEAD_BEEF);
  endtask

  initial begin
    fork
      begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_map();
        t_sync_fall();
        t_w1c();
        t_rise();
        t_both();
        t_level();
        t_setwins();
        t_irq();
        t_latch();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule